// File: doc/BRIEF.md
# Bit-Group Rotate, Shift and Bit-Manipulation Unit

This unit executes the bit-manipulation opcode group of an 8-bit processor core. The decoder supplies four things: the second opcode byte, the operand byte already fetched from the register file or from memory, the current flag byte, and a qualifier that marks the indexed form of the group. The unit returns four things: the result byte, the updated flag byte, the destination register index, and two write enables. One enable is for memory write-back and the other is for register-file write-back. The unit does not fetch operands, form addresses or decode other groups.

The opcode splits into three fields. The two top bits pick the class: rotate/shift, bit test, bit clear or bit set. The middle three bits pick either the shift kind or the bit number. The low three bits name the operand. In the indexed form the operand is always the memory byte. A writing operation then stores its result to memory, and it also copies the result into the register named by the low field, unless that field names memory.

With `OUT_REG` = 1 (the default), every output is registered and appears one clock after the request. With `OUT_REG` = 0 the outputs follow the inputs combinationally.

Top module: `bitgrp_unit`

## Requirements
- R1: `dest_reg_o` equals opcode bits 2:0. The operand codes are 0=b, 1=c, 2=d, 3=e, 4=h, 5=l, 6=memory, 7=a. With `OUT_REG`=1 every output reflects the request of the previous clock.
- R2: Opcodes 0x00–0x3F are rotates and shifts, and opcode bits 5:3 select the kind. 0=rotate left circular, 1=rotate right circular, 2=rotate left through carry, 3=rotate right through carry, 4=arithmetic left shift inserting 0, 5=arithmetic right shift keeping bit 7, 6=left shift inserting 1, 7=logical right shift inserting 0. The circular rotates copy the bit that leaves into the vacated bit.
- R3: Kind 6 shifts left, sets bit 0 to 1 and moves old bit 7 into carry.
- R4: The flag byte layout is S=bit 7, Z=bit 6, H=bit 4, P=bit 2, N=bit 1, C=bit 0. After a rotate or shift, C is the bit shifted out, S is result bit 7, Z is 1 when the result is zero, P is 1 when the result has an even number of ones, H and N are 0, and bits 5 and 3 pass through from `flags_i`.
- R5: Opcodes 0x40–0x7F test bit (opcode bits 5:3) of the operand. Z becomes the inverse of that bit, H becomes 1, N becomes 0, and every other flag bit passes through. The result equals the operand and neither write enable is raised.
- R6: Opcodes 0x80–0xBF clear the indexed bit and 0xC0–0xFF set it. All other bits are kept and the flag byte passes through unchanged.
- R7: When not indexed, a writing operation raises `mem_we_o` alone if the operand field is 6, and `reg_we_o` alone otherwise.
- R8: When indexed, a writing operation always raises `mem_we_o`. It also raises `reg_we_o` when the operand field is not 6.
- R9: While `rst_ni` is low, `valid_o`, `mem_we_o` and `reg_we_o` are 0.
- R10: A clock without `valid_i` produces `valid_o`, `mem_we_o` and `reg_we_o` all 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| opcode_i | input | 8 | Second opcode byte of the group |
| operand_i | input | 8 | Operand byte |
| flags_i | input | 8 | Current flag byte |
| indexed_i | input | 1 | Indexed form qualifier |
| valid_o | output | 1 | Result strobe |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | Updated flag byte |
| dest_reg_o | output | 3 | Destination register index |
| mem_we_o | output | 1 | Write result to memory |
| reg_we_o | output | 1 | Write result to register file |

## Verification
The bench builds the unit with the default `OUT_REG`=1, so it covers the registered path and the embedded assertions. It sweeps all 256 opcodes in both the plain and the indexed form. Each opcode is paired with operand bytes that hit zero, the single-ended bits and alternating patterns, and with flag bytes that have carry both set and clear, so that every rotate-through-carry input, every parity outcome and every tested-bit polarity is reached. Idle cycles and reset are also checked for silent write enables.

// File: rtl/bitgrp_pkg.sv
package bitgrp_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;

  localparam int FLG_C = 0;
  localparam int FLG_N = 1;
  localparam int FLG_P = 2;
  localparam int FLG_H = 4;
  localparam int FLG_Z = 6;
  localparam int FLG_S = 7;

  localparam logic [SEL_W-1:0] MEM_SEL = 3'd6;

  typedef enum logic [1:0] {
    GRP_ROT  = 2'd0,
    GRP_TEST = 2'd1,
    GRP_CLR  = 2'd2,
    GRP_SET  = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    ROT_LC  = 3'd0,
    ROT_RC  = 3'd1,
    ROT_LT  = 3'd2,
    ROT_RT  = 3'd3,
    SH_LA   = 3'd4,
    SH_RA   = 3'd5,
    SH_L1   = 3'd6,
    SH_RL   = 3'd7
  } rot_e;
endpackage

// File: rtl/bitgrp_rot.sv
module bitgrp_rot
  import bitgrp_pkg::*;
(
  input  rot_e              kind_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int MSB = DATA_W - 1;

  logic left;
  logic fill;

  always_comb begin
    left = 1'b0;
    fill = 1'b0;
    unique case (kind_i)
      ROT_LC: begin left = 1'b1; fill = data_i[MSB]; end
      ROT_RC: begin left = 1'b0; fill = data_i[0];   end
      ROT_LT: begin left = 1'b1; fill = carry_i;     end
      ROT_RT: begin left = 1'b0; fill = carry_i;     end
      SH_LA:  begin left = 1'b1; fill = 1'b0;        end
      SH_RA:  begin left = 1'b0; fill = data_i[MSB]; end
      SH_L1:  begin left = 1'b1; fill = 1'b1;        end
      SH_RL:  begin left = 1'b0; fill = 1'b0;        end
      default: ;
    endcase
    if (left) begin
      res_o   = {data_i[MSB-1:0], fill};
      carry_o = data_i[MSB];
    end else begin
      res_o   = {fill, data_i[MSB:1]};
      carry_o = data_i[0];
    end
  end
endmodule

// File: rtl/bitgrp_bitop.sv
module bitgrp_bitop
  import bitgrp_pkg::*;
(
  input  grp_e              grp_i,
  input  logic [SEL_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] res_o,
  output logic              bit_zero_o
);
  logic [DATA_W-1:0] mask;

  always_comb begin
    mask       = '0;
    mask[idx_i] = 1'b1;
    bit_zero_o = ~|(data_i & mask);
    unique case (grp_i)
      GRP_CLR: res_o = data_i & ~mask;
      GRP_SET: res_o = data_i | mask;
      default: res_o = data_i;
    endcase
  end
endmodule

// File: rtl/bitgrp_unit.sv
module bitgrp_unit
  import bitgrp_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        opcode_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [7:0]        flags_i,
  input  logic              indexed_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [7:0]        flags_o,
  output logic [SEL_W-1:0]  dest_reg_o,
  output logic              mem_we_o,
  output logic              reg_we_o
);
  grp_e             grp;
  logic [2:0]       field;
  logic [SEL_W-1:0] sel;

  assign grp   = grp_e'(opcode_i[7:6]);
  assign field = opcode_i[5:3];
  assign sel   = opcode_i[2:0];

  logic [DATA_W-1:0] rot_res, bit_res, res_d;
  logic              rot_c, bit_z;
  logic [7:0]        flg_d;
  logic              wr, mem_we_d, reg_we_d;

  bitgrp_rot u_rot (
    .kind_i  (rot_e'(field)),
    .data_i  (operand_i),
    .carry_i (flags_i[FLG_C]),
    .res_o   (rot_res),
    .carry_o (rot_c)
  );

  bitgrp_bitop u_bitop (
    .grp_i      (grp),
    .idx_i      (field),
    .data_i     (operand_i),
    .res_o      (bit_res),
    .bit_zero_o (bit_z)
  );

  always_comb begin
    flg_d = flags_i;
    unique case (grp)
      GRP_ROT: begin
        res_d        = rot_res;
        flg_d[FLG_S] = rot_res[DATA_W-1];
        flg_d[FLG_Z] = ~|rot_res;
        flg_d[FLG_H] = 1'b0;
        flg_d[FLG_P] = ~^rot_res;
        flg_d[FLG_N] = 1'b0;
        flg_d[FLG_C] = rot_c;
      end
      GRP_TEST: begin
        res_d        = operand_i;
        flg_d[FLG_Z] = bit_z;
        flg_d[FLG_H] = 1'b1;
        flg_d[FLG_N] = 1'b0;
      end
      default: res_d = bit_res;
    endcase
  end

  // indexed form: memory always written, named register also gets a copy
  assign wr       = valid_i && (grp != GRP_TEST);
  assign mem_we_d = wr && (indexed_i || sel == MEM_SEL);
  assign reg_we_d = wr && (sel != MEM_SEL);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o    <= 1'b0;
        mem_we_o   <= 1'b0;
        reg_we_o   <= 1'b0;
        result_o   <= '0;
        flags_o    <= '0;
        dest_reg_o <= '0;
      end else begin
        valid_o  <= valid_i;
        mem_we_o <= mem_we_d;
        reg_we_o <= reg_we_d;
        if (valid_i) begin
          result_o   <= res_d;
          flags_o    <= flg_d;
          dest_reg_o <= sel;
        end
      end
    end

    p_dest_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (valid_o && dest_reg_o == $past(opcode_i[2:0])));
    p_test_nowr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && opcode_i[7:6] == 2'b01) |=> (!mem_we_o && !reg_we_o));
    p_test_keepc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && opcode_i[7:6] == 2'b01) |=> (flags_o[FLG_C] == $past(flags_i[FLG_C])));
    p_flag_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && opcode_i[7]) |=> (flags_o == $past(flags_i)));
    p_plain_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !indexed_i) |=> !(mem_we_o && reg_we_o));
    p_idx_mem_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && indexed_i && opcode_i[7:6] != 2'b01) |=> mem_we_o);
    p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> (!valid_o && !mem_we_o && !reg_we_o));
  end else begin : g_comb
    assign valid_o    = valid_i;
    assign mem_we_o   = mem_we_d;
    assign reg_we_o   = reg_we_d;
    assign result_o   = res_d;
    assign flags_o    = flg_d;
    assign dest_reg_o = sel;
  end
endmodule

// File: tb/sim_bitgrp_unit.sv
`timescale 1ns/1ps
module sim_bitgrp_unit;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] opcode_i = '0;
  logic [7:0] operand_i = '0;
  logic [7:0] flags_i = '0;
  logic       indexed_i = 1'b0;
  logic       valid_o;
  logic [7:0] result_o;
  logic [7:0] flags_o;
  logic [2:0] dest_reg_o;
  logic       mem_we_o;
  logic       reg_we_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bitgrp_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .opcode_i(opcode_i),
    .operand_i(operand_i), .flags_i(flags_i), .indexed_i(indexed_i),
    .valid_o(valid_o), .result_o(result_o), .flags_o(flags_o),
    .dest_reg_o(dest_reg_o), .mem_we_o(mem_we_o), .reg_we_o(reg_we_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h op=%02h d=%02h f=%02h x=%0b",
               req, act, exp, opcode_i, operand_i, flags_i, indexed_i);
    end
  endtask

  function automatic int parity_even(input int v);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += (v >> i) & 1;
    return ((ones % 2) == 0) ? 1 : 0;
  endfunction

  task automatic run_one(input int op, input int d, input int fi, input int idx);
    int grp = op / 64;
    int fld = (op / 8) % 8;
    int sel = op % 8;
    int ci  = fi % 2;
    int r, c, fo, we, mwe, rwe;
    string rtag;
    string ftag;
    r = 0; c = 0; fo = fi;
    rtag = "R2"; ftag = "R4";
    case (grp)
      0: begin
        case (fld)
          0: begin r = ((d * 2) + d / 128) % 256; c = d / 128; end
          1: begin r = d / 2 + (d % 2) * 128;     c = d % 2;   end
          2: begin r = (d * 2) % 256 + ci;        c = d / 128; end
          3: begin r = d / 2 + ci * 128;          c = d % 2;   end
          4: begin r = (d * 2) % 256;             c = d / 128; end
          5: begin r = d / 2 + (d / 128) * 128;   c = d % 2;   end
          6: begin r = (d * 2) % 256 + 1;         c = d / 128; rtag = "R3"; end
          default: begin r = d / 2;               c = d % 2;   end
        endcase
        fo = (r / 128) * 128 + ((r == 0) ? 64 : 0) + (fi & 8'h28)
           + parity_even(r) * 4 + c;
      end
      1: begin
        r = d;
        rtag = "R5"; ftag = "R5";
        fo = (fi & 8'b1010_1100) | 16 | ((((d >> fld) & 1) == 0) ? 64 : 0) | (fi & 1);
      end
      2: begin r = d & ~(1 << fld) & 255; rtag = "R6"; ftag = "R6"; end
      default: begin r = d | (1 << fld);  rtag = "R6"; ftag = "R6"; end
    endcase
    we  = (grp != 1) ? 1 : 0;
    mwe = (we == 1 && (idx == 1 || sel == 6)) ? 1 : 0;
    rwe = (we == 1 && sel != 6) ? 1 : 0;

    valid_i = 1'b1; opcode_i = op[7:0]; operand_i = d[7:0];
    flags_i = fi[7:0]; indexed_i = idx[0];
    @(negedge clk);
    check("R1 valid", int'(valid_o), 1);
    check("R1 dest", int'(dest_reg_o), sel);
    check(rtag, int'(result_o), r);
    check(ftag, int'(flags_o), fo);
    if (grp == 1) begin
      check("R5 nowrite", int'({mem_we_o, reg_we_o}), 0);
    end else if (idx == 1) begin
      check("R8 mem_we", int'(mem_we_o), mwe);
      check("R8 reg_we", int'(reg_we_o), rwe);
    end else begin
      check("R7 mem_we", int'(mem_we_o), mwe);
      check("R7 reg_we", int'(reg_we_o), rwe);
    end
  endtask

  initial begin
    #(200000 * 5.0);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int dv [7] = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'h5A, 8'hA5, 8'h3C};
    int fv [4] = '{8'h00, 8'hFF, 8'h29, 8'hD6};
    repeat (3) @(negedge clk);
    check("R9 valid", int'(valid_o), 0);
    check("R9 we", int'({mem_we_o, reg_we_o}), 0);
    // stimulus held high during reset must not reach the outputs
    valid_i = 1'b1; opcode_i = 8'hC7;
    @(negedge clk);
    check("R9 hold", int'({valid_o, mem_we_o, reg_we_o}), 0);
    valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10 idle", int'({valid_o, mem_we_o, reg_we_o}), 0);

    for (int x = 0; x < 2; x++)
      for (int op = 0; op < 256; op++)
        for (int di = 0; di < 7; di++)
          for (int fj = 0; fj < 4; fj++)
            run_one(op, dv[di], fv[fj], x);

    // an idle cycle after a writing request clears the enables
    valid_i = 1'b1; opcode_i = 8'hFE; operand_i = 8'h00; indexed_i = 1'b1;
    @(negedge clk);
    check("R8 pre-idle", int'(mem_we_o), 1);
    valid_i = 1'b0;
    @(negedge clk);
    check("R10 after write", int'({valid_o, mem_we_o, reg_we_o}), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule